// File: doc/BRIEF.md
# Packed Float24 Vector Loader

This block turns a stream of 32-bit words arriving on a data port into four-component vectors of 24-bit floating-point values. Each completed vector is written into an external vector memory at a destination index held by the block. After each write the index moves on by one, so a host can fill a run of consecutive vector slots with one index setup followed by a burst of words.

Two input encodings are accepted, chosen by a mode bit. In packed mode, three words hold four 24-bit components laid end to end. In float32 mode, each of four words holds one IEEE single, which the block converts to the 24-bit format. In both modes the first word feeds the highest component, so the components arrive in reverse order. A destination beyond the last valid slot suppresses the write and raises an error flag.

The 24-bit format has a sign bit at [23], a 7-bit exponent biased by 63 at [22:16], and a 16-bit mantissa at [15:0].

Top module: `f24_vec_loader`

## Requirements
- R1: After reset `mem_we` and `err` are 0, the destination index is 0 and no partial words are held.
- R2: In packed mode (`fmt_f32`=0), the third accepted word completes a vector. From words a, b, c: w = a[31:8], z = {a[7:0], b[31:16]}, y = {b[15:0], c[31:24]}, x = c[23:0]. `mem_vec` holds w at [95:72], z at [71:48], y at [47:24] and x at [23:0].
- R3: In float32 mode (`fmt_f32`=1), the fourth accepted word completes a vector. Word k, counted from 0, is converted into component 3-k, so word 0 goes to w and word 3 goes to x.
- R4: A single with exponent field e in 64..191 converts to {sign, e-64, mantissa[22:7]}.
- R5: A single with e below 64, zero and denormals included, converts to {sign, 23'b0}. A single with e above 191, infinity and NaN included, converts to {sign, 7'h7F, 16'hFFFF}.
- R6: The cycle after the completing word, `mem_we` is high for exactly one cycle, with `mem_idx` set to the current index. The index then increments by one.
- R7: A completed vector whose index is above 95 is not written. `err` goes high and stays high, and the index does not change.
- R8: An index-setup write loads the index, discards any partial words and clears `err`. If a word write arrives in the same cycle, the index-setup write wins and the word is dropped.
- R9: A cycle with `word_we` low changes nothing, so words may arrive with gaps between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| word_we | input | 1 | Data word write strobe |
| word_data | input | 32 | Data word |
| fmt_f32 | input | 1 | 1: float32 words, 0: packed 24-bit words |
| idx_we | input | 1 | Index-setup write strobe |
| idx_data | input | 7 | New destination index |
| mem_we | output | 1 | Vector memory write strobe |
| mem_idx | output | 7 | Vector memory write index |
| mem_vec | output | 96 | Vector written, {w,z,y,x} |
| err | output | 1 | Sticky out-of-range destination flag |

## Verification
The bench drives the index across slot 95 and expects one last write at 95 followed by a rejection. A design whose bound is off by one would either write slot 96 or refuse slot 95. It converts singles at the exponent edges 63, 64, 191 and 192, where a wrong rebias or clamp would produce a wrapped exponent instead of zero or the maximum. It changes the mode part-way through a vector and issues index-setup writes mid-vector and together with word writes. A design that kept stale partial words, or that let the word through, would commit vectors at the wrong word count or to the wrong slot.

// File: rtl/f24_vload_pkg.sv
package f24_vload_pkg;
    localparam int WORD_W    = 32;
    localparam int F24_W     = 24;
    localparam int F24_EXP_W = 7;
    localparam int F24_MAN_W = 16;
    localparam int F24_BIAS  = 63;
    localparam int F32_BIAS  = 127;
    localparam int N_COMP    = 4;
    localparam int PACK_WORDS = 3;
    localparam int F32_WORDS  = 4;

    typedef logic [F24_W-1:0] f24_t;
    typedef logic [N_COMP-1:0][F24_W-1:0] vec4_t;   // [3]=w ... [0]=x
    typedef logic [N_COMP-1:0][WORD_W-1:0] wbuf_t;
endpackage

// File: rtl/f24_from_f32.sv
module f24_from_f32
    import f24_vload_pkg::*;
(
    input  logic [WORD_W-1:0] f32_i,
    output f24_t              f24_o
);
    localparam int SHIFT   = F32_BIAS - F24_BIAS;
    localparam int EXP_TOP = (1 << F24_EXP_W) - 1;
    localparam int E_HI    = SHIFT + EXP_TOP;

    logic       sgn;
    logic [7:0] exp8;
    logic [7:0] exp_re;

    always_comb begin
        sgn    = f32_i[31];
        exp8   = f32_i[30:23];
        exp_re = exp8 - 8'(SHIFT);
        if (int'(exp8) < SHIFT)
            f24_o = {sgn, {(F24_W-1){1'b0}}};
        else if (int'(exp8) > E_HI)
            f24_o = {sgn, {(F24_W-1){1'b1}}};
        else
            f24_o = {sgn, exp_re[F24_EXP_W-1:0], f32_i[22 -: F24_MAN_W]};
    end
endmodule

// File: rtl/f24_unpack3.sv
module f24_unpack3
    import f24_vload_pkg::*;
(
    input  logic [WORD_W-1:0] wa_i,
    input  logic [WORD_W-1:0] wb_i,
    input  logic [WORD_W-1:0] wc_i,
    output vec4_t             vec_o
);
    always_comb begin
        vec_o[3] = wa_i[31:8];
        vec_o[2] = {wa_i[7:0], wb_i[31:16]};
        vec_o[1] = {wb_i[15:0], wc_i[31:24]};
        vec_o[0] = wc_i[23:0];
    end
endmodule

// File: rtl/f24_vec_loader.sv
module f24_vec_loader
    import f24_vload_pkg::*;
#(
    parameter int NUM_VEC = 96,
    parameter int IDX_W   = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_we,
    input  logic [31:0]       word_data,
    input  logic              fmt_f32,
    input  logic              idx_we,
    input  logic [IDX_W-1:0]  idx_data,
    output logic              mem_we,
    output logic [IDX_W-1:0]  mem_idx,
    output logic [95:0]       mem_vec,
    output logic              err
);
    localparam int CNT_W   = $clog2(N_COMP);
    localparam int MAX_IDX = NUM_VEC - 1;

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic [CNT_W-1:0] cnt;
        wbuf_t            wbuf;
        logic             err;
        logic             mem_we;
        logic [IDX_W-1:0] mem_idx;
        vec4_t            mem_vec;
    } state_t;

    state_t st_d, st_q;
    wbuf_t  cur;
    vec4_t  pack_vec, f32_vec;
    logic   done;

    always_comb begin
        cur = st_q.wbuf;
        cur[st_q.cnt] = word_data;
    end

    f24_unpack3 u_unpack (
        .wa_i (cur[0]),
        .wb_i (cur[1]),
        .wc_i (cur[2]),
        .vec_o(pack_vec)
    );

    for (genvar k = 0; k < N_COMP; k++) begin : g_cvt
        f24_from_f32 u_cvt (
            .f32_i(cur[k]),
            .f24_o(f32_vec[N_COMP-1-k])
        );
    end

    always_comb begin
        st_d        = st_q;
        st_d.mem_we = 1'b0;
        done = ({1'b0, st_q.cnt} + (CNT_W+1)'(1)) >=
               (fmt_f32 ? (CNT_W+1)'(F32_WORDS) : (CNT_W+1)'(PACK_WORDS));
        if (idx_we) begin
            st_d.idx = idx_data;
            st_d.cnt = '0;
            st_d.err = 1'b0;
        end else if (word_we) begin
            st_d.wbuf = cur;
            if (done) begin
                st_d.cnt = '0;
                if (int'(st_q.idx) > MAX_IDX) begin
                    st_d.err = 1'b1;
                end else begin
                    st_d.mem_we  = 1'b1;
                    st_d.mem_idx = st_q.idx;
                    st_d.mem_vec = fmt_f32 ? f32_vec : pack_vec;
                    st_d.idx     = st_q.idx + IDX_W'(1);
                end
            end else begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mem_we  = st_q.mem_we;
    assign mem_idx = st_q.mem_idx;
    assign mem_vec = st_q.mem_vec;
    assign err     = st_q.err;

    // R7
    idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> int'(mem_idx) <= MAX_IDX);

    // R6
    we_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);

    // R9
    we_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> $past(word_we) && !$past(idx_we));

    // R8
    setup_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(idx_we) |-> !mem_we && !err);

    // R7
    err_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> !mem_we);
endmodule

// File: tb/f24_vec_loader_tb_top.sv
`timescale 1ns/1ps
module f24_vec_loader_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        word_we = 1'b0;
    logic [31:0] word_data = '0;
    logic        fmt_f32 = 1'b0;
    logic        idx_we = 1'b0;
    logic [6:0]  idx_data = '0;
    logic        mem_we;
    logic [6:0]  mem_idx;
    logic [95:0] mem_vec;
    logic        err;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    // model state
    int          m_idx = 0;
    int          m_cnt = 0;
    logic [31:0] m_buf [4];
    bit          m_err = 1'b0;

    always #10 clk = ~clk;

    f24_vec_loader dut_i (
        .clk(clk), .rst_n(rst_n), .word_we(word_we), .word_data(word_data),
        .fmt_f32(fmt_f32), .idx_we(idx_we), .idx_data(idx_data),
        .mem_we(mem_we), .mem_idx(mem_idx), .mem_vec(mem_vec), .err(err)
    );

    function automatic logic [23:0] cvt(input logic [31:0] f);
        int e = int'(f[30:23]);
        if (e < 64)  return {f[31], 23'd0};
        if (e > 191) return {f[31], 7'h7F, 16'hFFFF};
        return {f[31], 7'(e - 64), f[22:7]};
    endfunction

    function automatic logic [95:0] unpack(input logic [31:0] a, input logic [31:0] b,
                                           input logic [31:0] c);
        return {a[31:8], a[7:0], b[31:16], b[15:0], c[31:24], c[23:0]};
    endfunction

    task automatic check(input string tag, input bit ok, input logic [127:0] act,
                         input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(input bit we, input logic [31:0] d, input bit f32,
                        input bit iw, input logic [6:0] iv);
        bit          e_we = 1'b0;
        int          e_idx = 0;
        logic [95:0] e_vec = '0;
        string       tag;
        @(negedge clk);
        word_we = we; word_data = d; fmt_f32 = f32; idx_we = iw; idx_data = iv;
        tag = "R9";
        if (iw) begin
            m_idx = int'(iv); m_cnt = 0; m_err = 1'b0; tag = "R8";
        end else if (we) begin
            m_buf[m_cnt] = d;
            if (m_cnt + 1 >= (f32 ? 4 : 3)) begin
                m_cnt = 0;
                if (m_idx > 95) begin
                    m_err = 1'b1; tag = "R7";
                end else begin
                    e_we = 1'b1; e_idx = m_idx;
                    e_vec = f32 ? {cvt(m_buf[0]), cvt(m_buf[1]), cvt(m_buf[2]), cvt(m_buf[3])}
                                : unpack(m_buf[0], m_buf[1], m_buf[2]);
                    m_idx = (m_idx + 1) % 128;
                    tag = f32 ? "R3" : "R2";
                end
            end else begin
                m_cnt++;
            end
        end
        @(posedge clk);
        #5;
        check({tag, "/R6 we"}, mem_we === e_we, 128'(mem_we), 128'(e_we));
        if (e_we) begin
            check({tag, "/R6 idx"}, mem_idx === 7'(e_idx), 128'(mem_idx), 128'(e_idx));
            check({tag, " vec"}, mem_vec === e_vec, 128'(mem_vec), 128'(e_vec));
        end
        check({tag, " err"}, err === m_err, 128'(err), 128'(m_err));
    endtask

    task automatic idle();
        step(1'b0, 32'hDEADBEEF, 1'b0, 1'b0, 7'd0);
    endtask

    function automatic logic [31:0] rnd_word();
        logic [31:0] w = $urandom;
        case ($urandom_range(0, 7))
            0: w[30:23] = 8'd0;
            1: w[30:23] = 8'd255;
            2: w[30:23] = 8'd63;
            3: w[30:23] = 8'd64;
            4: w[30:23] = 8'd191;
            5: w[30:23] = 8'd192;
            default: ;
        endcase
        return w;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog actual=running expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1357));
        for (int k = 0; k < 4; k++) m_buf[k] = '0;
        repeat (3) @(posedge clk);
        #5;
        // R1 reset state
        check("R1 reset", mem_we === 1'b0 && err === 1'b0, {mem_we, err}, 0);
        rst_n = 1'b1;

        // R2 directed packed vector into index 0 (R1 index 0)
        step(1, 32'h11223344, 0, 0, 0);
        step(1, 32'h55667788, 0, 0, 0);
        step(1, 32'h99AABBCC, 0, 0, 0);
        check("R2 fields", mem_vec === 96'h112233_445566_778899_AABBCC && mem_idx === 7'd0,
              128'(mem_vec), 128'(96'h112233_445566_778899_AABBCC));

        // R3/R4 directed float32, word order reversed, with a gap (R9)
        step(1, 32'h3F800000, 1, 0, 0);
        idle();
        step(1, 32'h40000000, 1, 0, 0);
        step(1, 32'hBF800000, 1, 0, 0);
        step(1, 32'h00000000, 1, 0, 0);
        check("R3/R4 order", mem_vec === 96'h3F0000_400000_BF0000_000000 && mem_idx === 7'd1,
              128'(mem_vec), 128'(96'h3F0000_400000_BF0000_000000));

        // R5 clamps: underflow, overflow, infinity, negative zero
        step(1, 32'h1F812345, 1, 0, 0);
        step(1, 32'h60000001, 1, 0, 0);
        step(1, 32'hFF800000, 1, 0, 0);
        step(1, 32'h80000000, 1, 0, 0);
        check("R5 clamp", mem_vec === 96'h000000_7FFFFF_FFFFFF_800000,
              128'(mem_vec), 128'(96'h000000_7FFFFF_FFFFFF_800000));

        // R8 setup mid-vector discards partial, and wins over simultaneous word
        step(1, 32'hAAAAAAAA, 0, 0, 0);
        step(1, 32'hBBBBBBBB, 0, 1, 7'd94);
        step(1, 32'h01020304, 0, 0, 0);
        step(1, 32'h05060708, 0, 0, 0);
        step(1, 32'h090A0B0C, 0, 0, 0);
        check("R8 idx", mem_idx === 7'd94, 128'(mem_idx), 128'(94));

        // R7 boundary: 95 written, 96 rejected, index held
        for (int v = 0; v < 3; v++) step(1, $urandom, 0, 0, 0);
        check("R7 idx95", mem_idx === 7'd95, 128'(mem_idx), 128'(95));
        for (int v = 0; v < 3; v++) step(1, $urandom, 0, 0, 0);
        for (int v = 0; v < 4; v++) step(1, $urandom, 1, 0, 0);
        check("R7 sticky", err === 1'b1 && mem_we === 1'b0, {err, mem_we}, 2'b10);
        step(0, 0, 0, 1, 7'd5);

        // mode change mid-vector
        step(1, rnd_word(), 1, 0, 0);
        step(1, rnd_word(), 1, 0, 0);
        step(1, rnd_word(), 1, 0, 0);
        step(1, rnd_word(), 0, 0, 0);

        // random mix
        for (int n = 0; n < 3000; n++) begin
            int r = $urandom_range(0, 99);
            bit f = ($urandom_range(0, 9) == 0) ? ~fmt_f32 : fmt_f32;
            if (r < 3)       step(r[0], rnd_word(), f, 1, 7'($urandom_range(80, 127)));
            else if (r < 5)  step(1, rnd_word(), f, 1, 7'($urandom_range(0, 95)));
            else if (r < 20) idle();
            else             step(1, rnd_word(), f, 0, 0);
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule